// File: doc/BRIEF.md
# Phase-Accumulator Cosine Synthesizer Core

The core produces a digital cosine waveform whose frequency is set by a 32-bit tuning word. On every reference clock a 32-bit phase accumulator adds the active tuning word, so the output frequency is `fout = ftw * fclk / 2^32`. A 5-bit phase offset is added to the top bits of the accumulator phase, which gives offsets in steps of 360/32 = 11.25 degrees. The top 12 bits of the offset phase address a quarter-wave magnitude table that is folded by quadrant, and the result is registered as a signed 10-bit sample. A clock-out bit is taken as the inverted sign of that sample and is registered one cycle after it.

Software loads the tuning word, the phase offset and a power-down flag into a staging register, which sits outside this block and drives the `*_i` control inputs. The core copies those inputs into its active set only when `update_i` is high at a clock edge. While the active power-down flag is set, the accumulator, the sample and the clock-out bit all hold their values. Counting resumes from the held phase once the flag is cleared. A synchronous clear returns the phase to zero. To keep alias images at `k*fclk ± fout` well away from the band of interest, tuning words should stay below about a third of 2^32.

Top module: `dds_core`

## Requirements
- R1: While `rst_ni` is low, `phase_acc_o`, `sample_o` and `clk_o` are all zero. The active tuning word, phase offset and power-down flag also reset to zero.
- R2: At each clock edge where the active power-down flag is clear and `clr_i` is low, `phase_acc_o` advances by the active tuning word, modulo 2^32.
- R3: `ftw_i`, `phase_ofs_i` and `pdn_i` have no effect unless `update_i` is high at an edge. A word loaded at edge t is first added at edge t+1.
- R4: The converter address is the top 12 accumulator bits plus the active phase offset placed in address bits [11:7]. Examples with a zero accumulator: an offset of 8 gives a sample of 0, and an offset of 16 gives -511.
- R5: One edge after the accumulator holds phase P, `sample_o` equals round(511*cos(2*pi*A/4096)) within 1 LSB, where A is the 12-bit address derived from P. The sample is two's complement, and -512 never occurs.
- R6: When the active power-down flag is clear, `clk_o` after an edge equals the inverse of bit 9 of the `sample_o` value that held before that edge.
- R7: While the active power-down flag is set, `phase_acc_o`, `sample_o` and `clk_o` hold. After the flag clears, the accumulation continues from the held phase.
- R8: `clr_i` high at an edge sets `phase_acc_o` to zero after that edge, even during power-down.
- R9: With a tuning word of 2^(32-k) applied from phase zero, the phase reaches 2^31 after 2^(k-1) cycles. It returns to exactly zero after 2^k cycles, which is one full wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous phase clear |
| update_i | input | 1 | Strobe that copies the staged control inputs into the active set |
| ftw_i | input | 32 | Staged frequency tuning word |
| phase_ofs_i | input | 5 | Staged phase offset, 11.25 degrees per step |
| pdn_i | input | 1 | Staged power-down flag |
| phase_acc_o | output | 32 | Current accumulator phase |
| sample_o | output | 10 | Signed cosine sample |
| clk_o | output | 1 | Inverted sample sign, registered |

## Verification
The bench builds the core with its default parameters: a 32-bit accumulator, a 5-bit offset, a 12-bit converter address and 10-bit samples. With these values the offset lands on exact quarter-wave points, and a 2^24 tuning word wraps the phase in 256 cycles. That puts the cosine zero crossing, the negative peak and a complete wrap within a short run. Random tuning words also reach every quadrant fold, including the end entry of the table.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam longint PI_Q30 = 64'sd3373259426;

  // round(amp_max * cos(pi/2 * j / 2^qtr_w)), fixed-point Taylor series in Q30
  function automatic int quarter_amp(input int j, input int qtr_w, input int amp_max);
    longint x, x2, t, s;
    x  = (longint'(j) * PI_Q30) >>> (qtr_w + 1);
    x2 = (x * x) >>> 30;
    t  = 64'sd1 <<< 30;
    s  = t;
    for (int k = 1; k <= 8; k++) begin
      t = -((t * x2) >>> 30) / longint'((2 * k - 1) * (2 * k));
      s = s + t;
    end
    if (s < 0) s = 0;
    return int'((s * longint'(amp_max) + (64'sd1 <<< 29)) >>> 30);
  endfunction

endpackage

// File: rtl/dds_ctrl.sv
module dds_ctrl #(
  parameter int ACC_W = 32,
  parameter int PW_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             update_i,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic [PW_W-1:0]  pw_i,
  input  logic             pdn_i,
  output logic [ACC_W-1:0] ftw_o,
  output logic [PW_W-1:0]  pw_o,
  output logic             pdn_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw_o <= '0;
      pw_o  <= '0;
      pdn_o <= 1'b0;
    end else if (update_i) begin
      ftw_o <= ftw_i;
      pw_o  <= pw_i;
      pdn_o <= pdn_i;
    end
  end

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic [ACC_W-1:0] ftw_i,
  output logic [ACC_W-1:0] acc_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_o <= '0;
    else if (clr_i)  acc_o <= '0;
    else if (!hold_i) acc_o <= acc_o + ftw_i;
  end

endmodule

// File: rtl/dds_cos_conv.sv
module dds_cos_conv
  import dds_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int AMP_W  = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic signed [AMP_W-1:0] sample_o
);

  localparam int QW      = ADDR_W - 2;
  localparam int QTR     = 1 << QW;
  localparam int MAG_W   = AMP_W - 1;
  localparam int AMP_MAX = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] qrom [0:QTR];

  for (genvar g = 0; g <= QTR; g++) begin : g_rom
    assign qrom[g] = MAG_W'(quarter_amp(g, QW, AMP_MAX));
  end

  logic [1:0]             quad;
  logic [QW:0]            idx;
  logic                   neg;
  logic [MAG_W-1:0]       mag;
  logic signed [AMP_W-1:0] val;

  always_comb begin
    quad = addr_i[ADDR_W-1 -: 2];
    // odd quadrants read the table mirrored
    idx  = quad[0] ? ((QW+1)'(QTR) - {1'b0, addr_i[QW-1:0]}) : {1'b0, addr_i[QW-1:0]};
    neg  = quad[1] ^ quad[0];
    mag  = qrom[idx];
    val  = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sample_o <= '0;
    else if (en_i) sample_o <= val;
  end

endmodule

// File: rtl/dds_core.sv
module dds_core #(
  parameter int ACC_W  = 32,
  parameter int PW_W   = 5,
  parameter int ADDR_W = 12,
  parameter int AMP_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             update_i,
  input  logic [ACC_W-1:0] ftw_i,
  input  logic [PW_W-1:0]  phase_ofs_i,
  input  logic             pdn_i,
  output logic [ACC_W-1:0] phase_acc_o,
  output logic [AMP_W-1:0] sample_o,
  output logic             clk_o
);

  logic [ACC_W-1:0]        ftw_act;
  logic [PW_W-1:0]         pw_act;
  logic                    pdn_act;
  logic [ACC_W-1:0]        acc_q;
  logic [ADDR_W-1:0]       cos_addr;
  logic signed [AMP_W-1:0] smp_q;

  dds_ctrl #(.ACC_W(ACC_W), .PW_W(PW_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .update_i(update_i),
    .ftw_i(ftw_i), .pw_i(phase_ofs_i), .pdn_i(pdn_i),
    .ftw_o(ftw_act), .pw_o(pw_act), .pdn_o(pdn_act)
  );

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .hold_i(pdn_act),
    .ftw_i(ftw_act), .acc_o(acc_q)
  );

  // offset occupies the top PW_W address bits
  assign cos_addr = acc_q[ACC_W-1 -: ADDR_W] + {pw_act, {(ADDR_W-PW_W){1'b0}}};

  dds_cos_conv #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_cos (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(!pdn_act),
    .addr_i(cos_addr), .sample_o(smp_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       clk_o <= 1'b0;
    else if (!pdn_act) clk_o <= ~smp_q[AMP_W-1];
  end

  assign phase_acc_o = acc_q;
  assign sample_o    = smp_q;

endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk #(
  parameter int ACC_W = 32,
  parameter int PW_W  = 5,
  parameter int AMP_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             update_i,
  input logic [ACC_W-1:0] ftw_act,
  input logic [PW_W-1:0]  pw_act,
  input logic             pdn_act,
  input logic [ACC_W-1:0] phase_acc_o,
  input logic [AMP_W-1:0] sample_o,
  input logic             clk_o
);

  a_r2_acc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !pdn_act) |=> phase_acc_o == $past(phase_acc_o + ftw_act));

  a_r3_no_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> ($stable(ftw_act) && $stable(pw_act) && $stable(pdn_act)));

  a_r6_clk_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_act |=> clk_o == ~$past(sample_o[AMP_W-1]));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_act && !clr_i) |=> ($stable(phase_acc_o) && $stable(sample_o) && $stable(clk_o)));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> phase_acc_o == '0);

  always_ff @(posedge clk_i) begin
    if (rst_ni) a_r5_no_min: assert (sample_o != {1'b1, {(AMP_W-1){1'b0}}});
  end

endmodule

bind dds_core dds_core_chk #(.ACC_W(ACC_W), .PW_W(PW_W), .AMP_W(AMP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .update_i(update_i),
  .ftw_act(ftw_act), .pw_act(pw_act), .pdn_act(pdn_act),
  .phase_acc_o(phase_acc_o), .sample_o(sample_o), .clk_o(clk_o)
);

// File: tb/dds_core_test.sv
`timescale 1ns/1ps
module dds_core_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic        update_i = 1'b0;
  logic [31:0] ftw_i = '0;
  logic [4:0]  phase_ofs_i = '0;
  logic        pdn_i = 1'b0;
  logic [31:0] phase_acc_o;
  logic [9:0]  sample_o;
  logic        clk_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  dds_core uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .update_i(update_i),
    .ftw_i(ftw_i), .phase_ofs_i(phase_ofs_i), .pdn_i(pdn_i),
    .phase_acc_o(phase_acc_o), .sample_o(sample_o), .clk_o(clk_o)
  );

  always #2.5 clk_i = ~clk_i;

  // reference state
  logic [31:0] acc_m, ftw_m;
  logic [4:0]  pw_m;
  logic        pdn_m;
  logic [9:0]  last_s;
  int          exp_s;
  bit          s_hold;
  logic        exp_clk;

  function automatic int cos_ref(input logic [31:0] acc, input logic [4:0] pw);
    logic [31:0] p;
    real r;
    p = acc + {pw, 27'd0};
    r = 511.0 * $cos(2.0 * 3.14159265358979 * real'(p[31:20]) / 4096.0);
    return int'(r);
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    int d;
    @(posedge clk_i);
    if (!pdn_m) begin
      exp_s   = cos_ref(acc_m, pw_m);
      s_hold  = 0;
      exp_clk = ~last_s[9];
    end else begin
      s_hold = 1;
    end
    if (clr_i)       acc_m = '0;
    else if (!pdn_m) acc_m = acc_m + ftw_m;
    if (update_i) begin
      ftw_m = ftw_i; pw_m = phase_ofs_i; pdn_m = pdn_i;
    end
    @(negedge clk_i);
    chk(phase_acc_o == acc_m, {"R2 phase ", tag}, phase_acc_o, acc_m);
    if (s_hold) begin
      chk(sample_o == last_s, {"R7 sample hold ", tag}, $signed(sample_o), $signed(last_s));
    end else begin
      d = int'($signed(sample_o)) - exp_s;
      chk(d >= -1 && d <= 1, {"R5 sample ", tag}, $signed(sample_o), exp_s);
    end
    chk(clk_o == exp_clk, {"R6 clk_o ", tag}, clk_o, exp_clk);
    last_s = sample_o;
  endtask

  task automatic load(input logic [31:0] f, input logic [4:0] p, input logic pd, input string tag);
    update_i = 1'b1; ftw_i = f; phase_ofs_i = p; pdn_i = pd;
    step(tag);
    update_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    chk(0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] held;
    process::self().srandom(32'd1234);
    acc_m = '0; ftw_m = '0; pw_m = '0; pdn_m = 1'b0; exp_clk = 1'b0;
    #12;
    @(negedge clk_i);
    chk(phase_acc_o == 0, "R1 reset phase", phase_acc_o, 0);
    chk(sample_o == 0, "R1 reset sample", sample_o, 0);
    chk(clk_o == 0, "R1 reset clk_o", clk_o, 0);
    last_s = sample_o;
    rst_ni = 1'b1;

    step("idle");
    chk($signed(sample_o) == 511, "R5 peak at zero phase", $signed(sample_o), 511);

    // R4 phase offset quarter points
    load(32'd0, 5'd8, 1'b0, "R4 load ofs8");
    step("R4 ofs8");
    chk(sample_o == 0, "R4 offset 8 gives zero", $signed(sample_o), 0);
    load(32'd0, 5'd16, 1'b0, "R4 load ofs16");
    step("R4 ofs16");
    chk($signed(sample_o) == -511, "R4 offset 16 gives -511", $signed(sample_o), -511);
    step("R6 after negative");
    chk(clk_o == 1'b0, "R6 clk_o low on negative", clk_o, 0);

    // R3 staged values ignored without strobe
    load(32'h0100_0000, 5'd0, 1'b0, "R3 load");
    ftw_i = 32'h7000_0000; phase_ofs_i = 5'd3; pdn_i = 1'b1;
    held = acc_m;
    for (int i = 0; i < 6; i++) step("R3 no strobe");
    chk(phase_acc_o == held + 32'h0600_0000, "R3 old word kept", phase_acc_o, held + 32'h0600_0000);

    // R7 power-down hold and resume
    load(32'h0123_4567, 5'd0, 1'b1, "R7 enter pdn");
    held = phase_acc_o;
    for (int i = 0; i < 5; i++) step("R7 pdn");
    chk(phase_acc_o == held, "R7 phase held", phase_acc_o, held);
    load(32'h0123_4567, 5'd0, 1'b0, "R7 leave pdn");
    step("R7 resume");
    chk(phase_acc_o == held + 32'h0123_4567, "R7 resume from held", phase_acc_o, held + 32'h0123_4567);

    // R8 clear, also while powered down
    clr_i = 1'b1; step("R8 clear"); clr_i = 1'b0;
    chk(phase_acc_o == 0, "R8 clear", phase_acc_o, 0);
    step("R8 post");
    load(32'h0123_4567, 5'd0, 1'b1, "R8 pdn");
    clr_i = 1'b1; step("R8 clear in pdn"); clr_i = 1'b0;
    chk(phase_acc_o == 0, "R8 clear in pdn", phase_acc_o, 0);

    // R9 single wrap with k = 8
    load(32'h0100_0000, 5'd0, 1'b0, "R9 load");
    clr_i = 1'b1; step("R9 clear"); clr_i = 1'b0;
    for (int i = 1; i <= 256; i++) begin
      step("R9 run");
      if (i == 128) chk(phase_acc_o == 32'h8000_0000, "R9 half way", phase_acc_o, 32'h8000_0000);
    end
    chk(phase_acc_o == 0, "R9 wrapped once", phase_acc_o, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      update_i    = ($urandom_range(0, 7) == 0);
      ftw_i       = $urandom();
      phase_ofs_i = 5'($urandom());
      pdn_i       = ($urandom_range(0, 5) == 0);
      clr_i       = ($urandom_range(0, 63) == 0);
      step("random");
    end
    update_i = 1'b0; clr_i = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule